// File: doc/BRIEF.md
# Banked GPIO Interrupt Aggregator

This block is the core of a general-purpose pin controller with interrupt generation. It groups its pins into banks of equal width, five banks of sixteen by default. For each pin it holds a direction bit and an output data bit. Each input pin passes through a two-flop synchronizer, and the block looks for rising and falling edges on the synchronized value. For each pin a rising-edge enable and a falling-edge enable choose which edges count. A counted edge sets a sticky status bit for that pin. Software clears the bit by writing a 1 to it.

The block raises two kinds of request. Each bank has a summary request, which is the OR of the status bits in that bank and is gated by that bank's bit in the bank-enable register. The lowest pins (eight by default) also have a dedicated request line each, which shows that pin's status bit gated by bank-enable bit 0. Every request goes to two CPU targets, so the block drives two identical copies of each request vector.

Two resets act differently. The hardware reset is asynchronous and active-low. It returns every register to its default. The software reset is synchronous and active-high. It leaves configuration, pin data and status as they are, and only clears the pending read data. Software reaches the registers through a simple word port. A write takes effect at the clock edge where it is presented. Read data appears one cycle after the read request.

Top module: `gpioIrqAggregator`

## Requirements
- R1: While hwRstN is low, and just after it is released, every direction, output, edge-enable, bank-enable and status bit is 0. So pinOe, pinOut, all request outputs and rdData read 0.
- R2: Holding swRst high for any number of cycles changes none of these: pinOe, pinOut, the edge enables, the bank enables, the status bits or the request outputs.
- R3: The address is {regSel[2:0], bankSel[2:0]}. The register selects are 0 direction (1 = output), 1 output data, 2 synchronized input, 3 rising-edge enable, 4 falling-edge enable, 5 status (write 1 to clear), 6 bank enable, 7 none. Bit i of the word at bank b maps to pin 16b+i. Direction and output data drive pinOe and pinOut. A read returns the selected word on rdData one cycle after rdEn. A write or read with bankSel of 5 or more has no effect and reads 0, except for select 6.
- R4: A change on pinIn is seen by a read whose capture edge is the third clock edge after the change. A read captured at the second edge still returns the old value.
- R5: A 0-to-1 change on a pin whose rising-edge enable is set sets that pin's status bit at the third clock edge after the change. Edges on pins whose matching enable is clear set nothing.
- R6: A 1-to-0 change on a pin whose falling-edge enable is set sets its status bit with the same latency as R5.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R8: bankIrqA[n] is 1 exactly when bank-enable bit n is 1 and some status bit of pins 16n+15..16n is set. Status bits stay set while their bank is disabled.
- R9: pinIrqA[i], for i in 0..7, is status bit i gated by bank-enable bit 0. No other pin affects it.
- R10: pinIrqB always equals pinIrqA, and bankIrqB always equals bankIrqA.
- R11: When an edge and a write-1-to-clear reach the same status bit at the same clock edge, the bit stays set.
- R12: A cycle with swRst high clears rdData to 0 at that clock edge, even if a read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Asynchronous active-low hardware reset |
| swRst | input | 1 | Synchronous active-high software reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | {register select, bank select} |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| pinIn | input | 80 | Pin input levels |
| pinOut | output | 80 | Pin output data |
| pinOe | output | 80 | Pin output enables (1 = drive) |
| pinIrqA | output | 8 | Dedicated pin requests, target A |
| pinIrqB | output | 8 | Dedicated pin requests, target B |
| bankIrqA | output | 5 | Bank summary requests, target A |
| bankIrqB | output | 5 | Bank summary requests, target B |

## Verification
The bench builds the block with its default parameters: five banks of sixteen pins and eight dedicated lines. With these values the three-bit bank field has unused codes 5 to 7, so the bench can show that writes to those codes are ignored. The bench also drives pin 79, the top pin of the last bank, and checks the bank-4 summary with both its enable states. Eight dedicated lines are enough to show that a bank-0 pin above the dedicated range raises only the summary request.

// File: rtl/gpioIrqPkg.sv
package gpioIrqPkg;

  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_IN   = 3'd2,
    REG_RISE = 3'd3,
    REG_FALL = 3'd4,
    REG_STAT = 3'd5,
    REG_BEN  = 3'd6,
    REG_NONE = 3'd7
  } regSel_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic dirWr;
    logic outWr;
    logic riseWr;
    logic fallWr;
    logic clrWr;
    logic benWr;
  } wrStrobe_t;

endpackage

// File: rtl/gpioIrqCtrl.sv
module gpioIrqCtrl
  import gpioIrqPkg::*;
#(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_SEL_W = 3,
  parameter int DATA_W     = 16,
  localparam int ADDR_W    = REG_SEL_W + BANK_SEL_W
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  logic                  swRst,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     readWord,
  output wrStrobe_t             strobe,
  output regSel_e               rdSel,
  output logic [BANK_SEL_W-1:0] bankSel,
  output logic [DATA_W-1:0]     rdData
);

  regSel_e regSel;
  logic    bankOk;
  logic    rdAllowed;

  always_comb begin
    regSel  = regSel_e'(addr[ADDR_W-1 -: REG_SEL_W]);
    bankSel = addr[BANK_SEL_W-1:0];
    bankOk  = int'(bankSel) < NUM_BANKS;
    rdSel   = regSel;
  end

  // The bank-enable register ignores the bank field
  assign rdAllowed = bankOk || (regSel == REG_BEN);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (regSel)
        REG_DIR:  strobe.dirWr  = bankOk;
        REG_OUT:  strobe.outWr  = bankOk;
        REG_RISE: strobe.riseWr = bankOk;
        REG_FALL: strobe.fallWr = bankOk;
        REG_STAT: strobe.clrWr  = bankOk;
        REG_BEN:  strobe.benWr  = 1'b1;
        default:  strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      rdData <= '0;
    end else if (swRst) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= rdAllowed ? readWord : '0;
    end
  end

endmodule

// File: rtl/gpioIrqDatapath.sv
module gpioIrqDatapath
  import gpioIrqPkg::*;
#(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_W     = 16,
  parameter int NUM_DIRECT = 8,
  parameter int BANK_SEL_W = 3,
  localparam int NUM_PINS  = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  wrStrobe_t             strobe,
  input  regSel_e               rdSel,
  input  logic [BANK_SEL_W-1:0] bankSel,
  input  logic [BANK_W-1:0]     wrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [BANK_W-1:0]     readWord,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_DIRECT-1:0] pinReq,
  output logic [NUM_BANKS-1:0]  bankReq
);

  logic [NUM_PINS-1:0]  statFlat;
  logic [NUM_PINS-1:0]  rdVec;
  logic [NUM_BANKS-1:0] benVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dirR, outR, riseR, fallR, statR;
    logic [BANK_W-1:0] syncA, syncB, prevR;
    logic [BANK_W-1:0] riseHit, fallHit, clrMask, rdW;
    logic              benR, hit;

    assign hit     = (int'(bankSel) == b);
    assign riseHit = syncB & ~prevR & riseR;
    assign fallHit = ~syncB & prevR & fallR;
    assign clrMask = (strobe.clrWr && hit) ? wrData : '0;

    always_ff @(posedge clk or negedge hwRstN) begin
      if (!hwRstN) begin
        dirR  <= '0;
        outR  <= '0;
        riseR <= '0;
        fallR <= '0;
        statR <= '0;
        syncA <= '0;
        syncB <= '0;
        prevR <= '0;
        benR  <= 1'b0;
      end else begin
        syncA <= pinIn[b*BANK_W +: BANK_W];
        syncB <= syncA;
        prevR <= syncB;
        if (strobe.dirWr && hit)  dirR  <= wrData;
        if (strobe.outWr && hit)  outR  <= wrData;
        if (strobe.riseWr && hit) riseR <= wrData;
        if (strobe.fallWr && hit) fallR <= wrData;
        if (strobe.benWr)         benR  <= wrData[b];
        // new edge takes priority over a clear
        statR <= (statR & ~clrMask) | riseHit | fallHit;
      end
    end

    always_comb begin
      unique case (rdSel)
        REG_DIR:  rdW = dirR;
        REG_OUT:  rdW = outR;
        REG_IN:   rdW = syncB;
        REG_RISE: rdW = riseR;
        REG_FALL: rdW = fallR;
        REG_STAT: rdW = statR;
        default:  rdW = '0;
      endcase
    end

    assign pinOe[b*BANK_W +: BANK_W]    = dirR;
    assign pinOut[b*BANK_W +: BANK_W]   = outR;
    assign statFlat[b*BANK_W +: BANK_W] = statR;
    assign rdVec[b*BANK_W +: BANK_W]    = rdW;
    assign benVec[b]                    = benR;
    assign bankReq[b]                   = benR & (|statR);
  end

  always_comb begin
    readWord = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bankSel) == b) readWord = rdVec[b*BANK_W +: BANK_W];
    end
    if (rdSel == REG_BEN) readWord = BANK_W'(benVec);
  end

  assign pinReq = statFlat[NUM_DIRECT-1:0] & {NUM_DIRECT{benVec[0]}};

endmodule

// File: rtl/gpioIrqAggregator.sv
module gpioIrqAggregator
  import gpioIrqPkg::*;
#(
  parameter int NUM_BANKS   = 5,
  parameter int BANK_W      = 16,
  parameter int NUM_DIRECT  = 8,
  localparam int NUM_PINS   = NUM_BANKS * BANK_W,
  localparam int BANK_SEL_W = $clog2(NUM_BANKS),
  localparam int ADDR_W     = REG_SEL_W + BANK_SEL_W
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  logic                  swRst,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BANK_W-1:0]     wrData,
  output logic [BANK_W-1:0]     rdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_DIRECT-1:0] pinIrqA,
  output logic [NUM_DIRECT-1:0] pinIrqB,
  output logic [NUM_BANKS-1:0]  bankIrqA,
  output logic [NUM_BANKS-1:0]  bankIrqB
);

  wrStrobe_t               strobe;
  regSel_e                 rdSel;
  logic [BANK_SEL_W-1:0]   bankSel;
  logic [BANK_W-1:0]       readWord;
  logic [NUM_DIRECT-1:0]   pinReq;
  logic [NUM_BANKS-1:0]    bankReq;

  gpioIrqCtrl #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_SEL_W(BANK_SEL_W),
    .DATA_W    (BANK_W)
  ) i_ctrl (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .swRst   (swRst),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .readWord(readWord),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .bankSel (bankSel),
    .rdData  (rdData)
  );

  gpioIrqDatapath #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .NUM_DIRECT(NUM_DIRECT),
    .BANK_SEL_W(BANK_SEL_W)
  ) i_datapath (
    .clk     (clk),
    .hwRstN  (hwRstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .bankSel (bankSel),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .readWord(readWord),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pinReq  (pinReq),
    .bankReq (bankReq)
  );

  // Two targets receive identical request copies
  assign pinIrqA  = pinReq;
  assign pinIrqB  = pinReq;
  assign bankIrqA = bankReq;
  assign bankIrqB = bankReq;

endmodule

// File: rtl/gpioIrqChecker.sv
module gpioIrqChecker #(
  parameter int NUM_BANKS  = 5,
  parameter int BANK_W     = 16,
  parameter int NUM_DIRECT = 8,
  localparam int NUM_PINS  = NUM_BANKS * BANK_W
) (
  input logic                  clk,
  input logic                  hwRstN,
  input logic                  swRst,
  input logic                  wrEn,
  input logic [BANK_W-1:0]     rdData,
  input logic [NUM_PINS-1:0]   pinOut,
  input logic [NUM_PINS-1:0]   pinOe,
  input logic [NUM_DIRECT-1:0] pinIrqA,
  input logic [NUM_DIRECT-1:0] pinIrqB,
  input logic [NUM_BANKS-1:0]  bankIrqA,
  input logic [NUM_BANKS-1:0]  bankIrqB
);

  // R1
  always @(posedge clk) begin
    if (!hwRstN) begin
      hw_reset_chk: assert (pinOe == '0 && pinOut == '0 && bankIrqA == '0 && pinIrqA == '0);
    end
  end

  // R10
  copy_match_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (pinIrqA == pinIrqB) && (bankIrqA == bankIrqB));

  // R3
  pin_hold_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    !wrEn |=> $stable(pinOut) && $stable(pinOe));

  // R9
  direct_in_bank_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (|pinIrqA) |-> bankIrqA[0]);

  // R7
  bank_drop_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (|($past(bankIrqA) & ~bankIrqA)) |-> $past(wrEn));

  // R12
  sw_clear_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    swRst |=> rdData == '0);

endmodule

bind gpioIrqAggregator gpioIrqChecker #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .NUM_DIRECT(NUM_DIRECT)
) i_gpioIrqChecker (
  .clk     (clk),
  .hwRstN  (hwRstN),
  .swRst   (swRst),
  .wrEn    (wrEn),
  .rdData  (rdData),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .pinIrqA (pinIrqA),
  .pinIrqB (pinIrqB),
  .bankIrqA(bankIrqA),
  .bankIrqB(bankIrqB)
);

// File: tb/test_gpioIrqAggregator.sv
module test_gpioIrqAggregator;

  localparam int NB = 5;
  localparam int BW = 16;
  localparam int ND = 8;
  localparam int NP = NB * BW;

  localparam logic [2:0] S_DIR = 3'd0, S_OUT = 3'd1, S_IN = 3'd2, S_RISE = 3'd3,
                         S_FALL = 3'd4, S_STAT = 3'd5, S_BEN = 3'd6;

  logic          clk = 1'b0;
  logic          hwRstN = 1'b0;
  logic          swRst = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [5:0]    addr = '0;
  logic [BW-1:0] wrData = '0;
  logic [BW-1:0] rdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic [ND-1:0] pinIrqA, pinIrqB;
  logic [NB-1:0] bankIrqA, bankIrqB;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpioIrqAggregator i_gpioIrqAggregator (
    .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinIrqA(pinIrqA), .pinIrqB(pinIrqB),
    .bankIrqA(bankIrqA), .bankIrqB(bankIrqB)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCopies();
    check("R10 pin copies", 128'(pinIrqB), 128'(pinIrqA));
    check("R10 bank copies", 128'(bankIrqB), 128'(bankIrqA));
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [2:0] bank, input logic [BW-1:0] d);
    addr = {sel, bank}; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] sel, input logic [2:0] bank, output logic [BW-1:0] d);
    addr = {sel, bank}; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testResetDefaults();
    logic [BW-1:0] d;
    check("R1 pinOe", 128'(pinOe), 128'(0));
    check("R1 pinOut", 128'(pinOut), 128'(0));
    check("R1 bank irq", 128'(bankIrqA), 128'(0));
    check("R1 pin irq", 128'(pinIrqA), 128'(0));
    check("R1 rdData", 128'(rdData), 128'(0));
    readReg(S_RISE, 3'd0, d);
    check("R1 rise enable", 128'(d), 128'(0));
  endtask

  task automatic testRegAccess();
    logic [BW-1:0] d;
    writeReg(S_DIR, 3'd2, 16'hA5C3);
    writeReg(S_OUT, 3'd2, 16'h0F0F);
    check("R3 pinOe bank2", 128'(pinOe), 128'(80'hA5C3) << 32);
    check("R3 pinOut bank2", 128'(pinOut), 128'(80'h0F0F) << 32);
    readReg(S_DIR, 3'd2, d);
    check("R3 dir readback", 128'(d), 128'(16'hA5C3));
    writeReg(S_DIR, 3'd6, 16'hFFFF);
    check("R3 bad bank write ignored", 128'(pinOe), 128'(80'hA5C3) << 32);
    readReg(S_DIR, 3'd6, d);
    check("R3 bad bank reads 0", 128'(d), 128'(0));
  endtask

  task automatic testInputSync();
    logic [BW-1:0] d;
    pinIn[17] = 1'b1;
    @(posedge clk); @(negedge clk);
    readReg(S_IN, 3'd1, d);
    check("R4 old value at second edge", 128'(d), 128'(0));
    readReg(S_IN, 3'd1, d);
    check("R4 new value at third edge", 128'(d), 128'(16'h0002));
  endtask

  task automatic testRising();
    logic [BW-1:0] d;
    writeReg(S_RISE, 3'd0, 16'h022C);
    writeReg(S_BEN, 3'd0, 16'h0001);
    pinIn[3] = 1'b1;
    cycles(2);
    check("R5 not yet set", 128'(bankIrqA), 128'(0));
    cycles(1);
    check("R5 pin3 irq", 128'(pinIrqA), 128'(8'h08));
    check("R5 bank0 irq", 128'(bankIrqA), 128'(5'b00001));
    checkCopies();
    pinIn[4] = 1'b1; cycles(4);
    pinIn[4] = 1'b0; cycles(4);
    readReg(S_STAT, 3'd0, d);
    check("R5 disabled edges ignored", 128'(d), 128'(16'h0008));
  endtask

  task automatic testClear();
    logic [BW-1:0] d;
    writeReg(S_STAT, 3'd0, 16'hFFF7);
    check("R7 zero write keeps bit", 128'(pinIrqA), 128'(8'h08));
    writeReg(S_STAT, 3'd0, 16'h0008);
    check("R7 one write clears", 128'(pinIrqA), 128'(0));
    readReg(S_STAT, 3'd0, d);
    check("R7 status cleared", 128'(d), 128'(0));
  endtask

  task automatic testFalling();
    logic [BW-1:0] d;
    writeReg(S_FALL, 3'd4, 16'h8000);
    writeReg(S_BEN, 3'd0, 16'h0011);
    pinIn[79] = 1'b1; cycles(5);
    check("R6 rise on fall-only pin ignored", 128'(bankIrqA), 128'(0));
    pinIn[79] = 1'b0;
    cycles(2);
    check("R6 not yet set", 128'(bankIrqA), 128'(0));
    cycles(1);
    check("R6 bank4 irq", 128'(bankIrqA), 128'(5'b10000));
    check("R6 no direct irq", 128'(pinIrqA), 128'(0));
    writeReg(S_BEN, 3'd0, 16'h0001);
    check("R8 bank4 gated off", 128'(bankIrqA), 128'(0));
    readReg(S_STAT, 3'd4, d);
    check("R8 status kept while gated", 128'(d), 128'(16'h8000));
    writeReg(S_BEN, 3'd3, 16'h0010);
    check("R8 bank4 re-enabled", 128'(bankIrqA), 128'(5'b10000));
    checkCopies();
  endtask

  task automatic testDirect();
    logic [BW-1:0] d;
    writeReg(S_BEN, 3'd0, 16'h0000);
    pinIn[5] = 1'b1; pinIn[9] = 1'b1;
    cycles(4);
    check("R9 gated by bank enable 0", 128'(pinIrqA), 128'(0));
    readReg(S_STAT, 3'd0, d);
    check("R9 status recorded", 128'(d), 128'(16'h0220));
    writeReg(S_BEN, 3'd0, 16'h0001);
    check("R9 only pin5 line", 128'(pinIrqA), 128'(8'h20));
    check("R9 bank0 summary", 128'(bankIrqA), 128'(5'b00001));
    writeReg(S_STAT, 3'd0, 16'h0020);
    check("R9 pin9 keeps only summary", 128'(pinIrqA), 128'(0));
    check("R8 pin9 summary", 128'(bankIrqA), 128'(5'b00001));
    checkCopies();
  endtask

  task automatic testEdgeWins();
    logic [BW-1:0] d;
    writeReg(S_STAT, 3'd0, 16'hFFFF);
    check("R7 bank0 cleared", 128'(bankIrqA), 128'(0));
    pinIn[2] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    writeReg(S_STAT, 3'd0, 16'h0004);
    check("R11 edge beats clear", 128'(pinIrqA), 128'(8'h04));
    readReg(S_STAT, 3'd0, d);
    check("R11 status set", 128'(d), 128'(16'h0004));
  endtask

  task automatic testSoftReset();
    logic [BW-1:0] d;
    check("R12 read data present", 128'(rdData), 128'(16'h0004));
    swRst = 1'b1; rdEn = 1'b1; addr = {S_STAT, 3'd0};
    cycles(3);
    swRst = 1'b0; rdEn = 1'b0;
    check("R12 rdData cleared", 128'(rdData), 128'(0));
    check("R2 pinOe kept", 128'(pinOe), 128'(80'hA5C3) << 32);
    check("R2 pinOut kept", 128'(pinOut), 128'(80'h0F0F) << 32);
    check("R2 pin irq kept", 128'(pinIrqA), 128'(8'h04));
    check("R2 bank irq kept", 128'(bankIrqA), 128'(5'b00001));
    readReg(S_STAT, 3'd4, d);
    check("R2 status kept", 128'(d), 128'(16'h8000));
    readReg(S_RISE, 3'd0, d);
    check("R2 rise enable kept", 128'(d), 128'(16'h022C));
    readReg(S_BEN, 3'd0, d);
    check("R2 bank enable kept", 128'(d), 128'(16'h0001));
  endtask

  task automatic testHardReset();
    logic [BW-1:0] d;
    hwRstN = 1'b0;
    #1;
    check("R1 async pinOe", 128'(pinOe), 128'(0));
    check("R1 async irq", 128'(pinIrqA), 128'(0));
    cycles(2);
    hwRstN = 1'b1;
    cycles(4);
    check("R1 pinOut after reset", 128'(pinOut), 128'(0));
    check("R1 bank irq after reset", 128'(bankIrqA), 128'(0));
    readReg(S_STAT, 3'd0, d);
    check("R1 status after reset", 128'(d), 128'(0));
    readReg(S_BEN, 3'd0, d);
    check("R1 bank enable after reset", 128'(d), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    testResetDefaults();
    hwRstN = 1'b1;
    cycles(2);
    testRegAccess();
    testInputSync();
    testRising();
    testClear();
    testFalling();
    testDirect();
    testEdgeWins();
    testSoftReset();
    testHardReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule